// File: doc/BRIEF.md
# Frame Readout Serializer with Data-Ready Flag

This block takes one finished conversion frame, 72 bits made of a 24-bit status word and two 24-bit channel samples, and delivers it to a host over the output line of a serial slave port. When a frame is captured, an active-low ready flag goes low so the host knows a result is waiting. The host then drives the serial clock. Each rising clock edge puts the next bit on the output line, starting with the most significant bit.

The ready flag returns high on any falling serial-clock edge. Chip select plays no part in this. Neither does what the host is doing, whether it reads data or writes a command on its own data line, which this block never looks at. The serial clock and chip select come from the host, so both are synchronized into the system clock and their edges are detected there. If a new frame is captured while a readout is under way, the bits being shifted are not disturbed. The new frame waits in a holding register and is offered, with the flag lowered again, once the current frame is finished.

Top module: `frame_readout_ser`

## Requirements
- R1: A frame is sent most significant bit first: after the n-th rising serial-clock edge with chip select low (n = 1..72), the output line carries frame bit 72-n.
- R2: Capturing a frame while no readout is under way pulls the ready flag low one system-clock cycle after the capture strobe.
- R3: Every falling serial-clock edge drives the ready flag high, whether chip select is high or low.
- R4: The output line changes only on rising serial-clock edges. It holds its value across the falling edge that follows.
- R5: While chip select is high the output line is 0, and rising edges do not advance the frame.
- R6: After all 72 bits have gone out, further rising edges leave the output line at 0.
- R7: A frame captured before its predecessor's readout has started replaces that predecessor, and readout restarts at bit 71.
- R8: A frame captured in the middle of a readout does not change the bits still to be sent or the ready flag. When the last bit of the current frame has gone out, that new frame becomes current and the ready flag goes low again.
- R9: After reset the ready flag is high and the output line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Frame capture strobe, one cycle |
| frame_in | input | 72 | Frame to capture: status in [71:48], channel 1 in [47:24], channel 2 in [23:0] |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| dout | output | 1 | Serial data to the host |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The bench toggles the serial clock with chip select high and expects the ready flag to release anyway. A design that gated the release with chip select would leave the flag low. Random mid-readout captures, at random bit positions, check that the frame in flight arrives intact and that the waiting frame follows it with the flag lowered. A design without the holding register would mix two frames or lose one. Back-to-back captures with no read in between must yield only the newest frame from bit 71, and a design that did not reset its bit count would start in the middle. Extra clocks after bit 0 must give zeros, which exposes a counter that wraps around.

// File: rtl/frame_readout_ser.sv
module frame_readout_ser #(
  parameter int FRAME_W     = 72,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               sclk,
  input  logic               cs_n,
  output logic               dout,
  output logic               drdy_n
);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy;
  logic                   sclk_d;
  logic [FRAME_W-1:0]     sh, pbuf;
  logic [CW-1:0]          left;
  logic                   pend, dout_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end

  wire sclk_q   = sclk_sy[SYNC_STAGES-1];
  wire cs_q     = cs_sy[SYNC_STAGES-1];
  wire rise     = sclk_q & ~sclk_d;
  wire fall     = ~sclk_q & sclk_d;
  wire in_prog  = (left != '0) && (left != FULL);
  wire take_new = load && !in_prog;
  wire promote  = pend && (left == '0) && !load;
  wire take     = take_new | promote;
  wire shift    = rise && !cs_q && !take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh     <= '0;
      pbuf   <= '0;
      left   <= '0;
      pend   <= 1'b0;
      dout_r <= 1'b0;
      drdy_n <= 1'b1;
    end else begin
      if (take) begin
        sh   <= take_new ? frame_in : pbuf;
        left <= FULL;
        pend <= 1'b0;
      end else if (shift) begin
        if (left != '0) begin
          dout_r <= sh[FRAME_W-1];
          sh     <= sh << 1;
          left   <= left - CW'(1);
        end else begin
          dout_r <= 1'b0;
        end
      end
      if (load && in_prog) begin
        pbuf <= frame_in;
        pend <= 1'b1;
      end
      if (take)      drdy_n <= 1'b0;
      else if (fall) drdy_n <= 1'b1;
    end

  assign dout = ~cs_q & dout_r;
endmodule

module frame_readout_ser_chk #(
  parameter int FRAME_W = 72,
  parameter int CW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          rise,
  input logic          fall,
  input logic          take,
  input logic          in_prog,
  input logic          cs_q,
  input logic [CW-1:0] left,
  input logic          drdy_n
);
  p_take_lowers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !drdy_n);

  p_fall_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !take |=> drdy_n);

  p_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise && !take |=> $stable(left));

  p_cs_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q && !take |=> $stable(left));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> left == CW'(FRAME_W));

  p_midload_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_prog && !fall |=> drdy_n == $past(drdy_n));
endmodule

bind frame_readout_ser frame_readout_ser_chk #(.FRAME_W(FRAME_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .rise(rise), .fall(fall),
  .take(take), .in_prog(in_prog), .cs_q(cs_q), .left(left), .drdy_n(drdy_n)
);

// File: tb/sim_frame_readout_ser.sv
`timescale 1ns/1ps
module sim_frame_readout_ser;
  logic        clk = 1'b0, rst_n = 1'b0, load = 1'b0, sclk = 1'b0, cs_n = 1'b1;
  logic [71:0] frame_in = '0;
  logic        dout, drdy_n;
  int          nchk = 0, nerr = 0;

  frame_readout_ser u0 (.clk(clk), .rst_n(rst_n), .load(load), .frame_in(frame_in),
                        .sclk(sclk), .cs_n(cs_n), .dout(dout), .drdy_n(drdy_n));

  always #2 clk = ~clk;

  function automatic logic exp_bit(input logic [71:0] f, input int n);
    return f[71-n];
  endfunction

  function automatic logic [71:0] rnd72();
    logic [71:0] f;
    f[71:64] = 8'($urandom());
    f[63:32] = $urandom();
    f[31:0]  = $urandom();
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [71:0] f);
    frame_in = f; load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  task automatic pulse(output logic b_hi, output logic b_lo, output logic rdy_hi);
    sclk = 1'b1; tick(6);
    b_hi = dout; rdy_hi = drdy_n;
    sclk = 1'b0; tick(6);
    b_lo = dout;
  endtask

  task automatic read_bits(input logic [71:0] f, input int first, input int n,
                           input string req, output logic rdy_last);
    logic bh, bl, rh;
    for (int i = 0; i < n; i++) begin
      pulse(bh, bl, rh);
      check(bh == exp_bit(f, first + i), req, 72'(bh), 72'(exp_bit(f, first + i)));
      check(bl == bh, "R4", 72'(bl), 72'(bh));
      rdy_last = rh;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [71:0] fa, fb;
    logic bh, bl, rh, rl;
    void'($urandom(32'd1292));
    tick(5); rst_n = 1'b1; tick(3);
    check(drdy_n == 1'b1, "R9", 72'(drdy_n), 72'(1));
    check(dout == 1'b0, "R9", 72'(dout), 72'(0));

    // R1 R2 R3: plain readout, flag released on first falling edge
    fa = 72'hA5C3_0F81_7E24_DB69_96;
    do_load(fa);
    check(drdy_n == 1'b0, "R2", 72'(drdy_n), 72'(0));
    cs_n = 1'b0; tick(4);
    pulse(bh, bl, rh);
    check(bh == fa[71], "R1", 72'(bh), 72'(fa[71]));
    check(drdy_n == 1'b1, "R3", 72'(drdy_n), 72'(1));
    read_bits(fa, 1, 71, "R1", rl);
    pulse(bh, bl, rh);
    check(bh == 1'b0 && bl == 1'b0, "R6", 72'({bh, bl}), 72'(0));
    pulse(bh, bl, rh);
    check(bh == 1'b0, "R6", 72'(bh), 72'(0));

    // R5 R3: clocking with chip select high releases the flag but sends nothing
    cs_n = 1'b1; tick(4);
    fb = rnd72();
    do_load(fb);
    check(drdy_n == 1'b0, "R2", 72'(drdy_n), 72'(0));
    pulse(bh, bl, rh);
    check(bh == 1'b0 && bl == 1'b0, "R5", 72'({bh, bl}), 72'(0));
    check(drdy_n == 1'b1, "R3", 72'(drdy_n), 72'(1));
    pulse(bh, bl, rh);
    cs_n = 1'b0; tick(4);
    read_bits(fb, 0, 72, "R5", rl);

    // R7: two captures without a read, the newest wins from bit 71
    fa = rnd72(); fb = rnd72();
    do_load(fa); tick(3);
    do_load(fb);
    check(drdy_n == 1'b0, "R7", 72'(drdy_n), 72'(0));
    read_bits(fb, 0, 72, "R7", rl);

    // R8: random mid-readout captures
    for (int it = 0; it < 6; it++) begin
      int k;
      fa = rnd72(); fb = rnd72();
      k = 1 + int'($urandom() % 70);
      do_load(fa);
      check(drdy_n == 1'b0, "R2", 72'(drdy_n), 72'(0));
      read_bits(fa, 0, k, "R1", rl);
      do_load(fb);
      tick(2);
      check(drdy_n == 1'b1, "R8", 72'(drdy_n), 72'(1));
      read_bits(fa, k, 72 - k, "R8", rl);
      check(rl == 1'b0, "R8", 72'(rl), 72'(0));
      read_bits(fb, 0, 72, "R8", rl);
      check(drdy_n == 1'b1, "R3", 72'(drdy_n), 72'(1));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule